// File: doc/BRIEF.md
# Temperature Limit Window Alert

This block watches a stream of temperature results and raises an alert when a reading leaves a programmable window. Each result is a 12-bit two's-complement word in steps of 0.0625 °C. It arrives with a one-cycle valid strobe and is compared against a high limit and a low limit. The comparison happens only on that strobe. Changing the limits, or anything else, starts no new comparison. The block keeps an over-limit flag and an under-limit flag, and it drives an alert pin whose active level can be selected.

The block has two operating styles. In window-follow (comparator) mode, the flags and the alert track the temperature. A flag is released only once the reading has moved back inside the limit by a programmable hysteresis margin. In latched (interrupt) mode, every excursion sets sticky flags and latches the alert. A register-read clear strobe drops both the flags and the alert. An alert-response success strobe drops only the alert. A registered cause bit records whether the latest excursion was over-limit or under-limit, for use by the logic that answers the alert response. A synchronous soft reset returns all state to its power-up values. The surrounding register logic holds the limits and the configuration. At power-up that logic sets the limits to the range ends (+127.9375 °C and −128 °C), so no alert can occur before software programs them.

Top module: `tlim_alert`

## Requirements
- R1: After reset, both flags and the cause bit are 0 and the alert is inactive. With the polarity input at 0, the pin reads 1.
- R2: In latched mode (`mode_intr`=1), a valid result strictly greater than the high limit sets the over flag and activates the alert. A result strictly below the low limit sets the under flag and activates the alert. A result equal to a limit sets nothing. Set flags remain set through later in-window results.
- R3: All comparisons treat the temperature and both limits as signed two's-complement values. For example, 0xE70 (−25 °C) is below a low limit of 0x000.
- R4: In window-follow mode (`mode_intr`=0), an over-limit result sets the over flag and an under-limit result sets the under flag. The over flag clears on a result ≤ high limit − margin. The under flag clears on a result ≥ low limit + margin. The alert is active exactly while either flag is set.
- R5: The hysteresis code `hys_code` selects the margin: 0→0, 1→16, 2→32 and 3→64 LSB (0, 1, 2 and 4 °C).
- R6: The release thresholds saturate at the ends of the 12-bit signed range (0x7FF and 0x800) and never wrap.
- R7: In latched mode, `cfg_rd_clr` clears both flags and the alert. In window-follow mode it has no effect.
- R8: In latched mode, `ares_ok` clears the alert and leaves both flags unchanged. In window-follow mode it has no effect.
- R9: With `pol_high`=0 the pin is low while the alert is active. With `pol_high`=1 the pin is high while the alert is active.
- R10: `alert_cause` is updated on each excursion: 1 for over-limit, 0 for under-limit. It holds its value otherwise.
- R11: `soft_rst` returns the flags, the alert and the cause bit to their reset values on the next clock edge, and it overrides every other input.
- R12: When a clear strobe and an out-of-window result arrive in the same cycle in latched mode, the new excursion wins and its flag and alert are set.
- R13: Without a valid result, the flags do not change even when the limits or the hysteresis code change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous return to power-up state |
| res_valid | input | 1 | New temperature result strobe |
| res_temp | input | 12 | Temperature result, signed, 0.0625 °C/LSB |
| lim_high | input | 12 | High limit, signed |
| lim_low | input | 12 | Low limit, signed |
| mode_intr | input | 1 | 1 = latched mode, 0 = window-follow mode |
| pol_high | input | 1 | 1 = pin active high, 0 = active low |
| hys_code | input | 2 | Hysteresis margin select |
| cfg_rd_clr | input | 1 | Register-read clear strobe |
| ares_ok | input | 1 | Alert-response success strobe |
| flag_hi | output | 1 | Over-limit flag |
| flag_lo | output | 1 | Under-limit flag |
| alert_o | output | 1 | Alert pin level |
| alert_cause | output | 1 | 1 = over-limit, 0 = under-limit |

## Verification
The bench builds the block with its default parameters: a 12-bit temperature and a margin step of 16 LSB per degree. With these values, the largest margin of 64 LSB can push a release threshold past either end of the signed range. The saturation corners are therefore reachable with limits placed near 0x7FF and 0x800. Each margin code is tested on a release that lands exactly on its threshold.

// File: rtl/tlim_pkg.sv
package tlim_pkg;

    typedef struct packed {
        logic fh;
        logic fl;
        logic alrt;
        logic cause;
    } tlim_state_t;

    function automatic int hys_lsb(input logic [1:0] code, input int step);
        case (code)
            2'd0:    hys_lsb = 0;
            2'd1:    hys_lsb = step;
            2'd2:    hys_lsb = 2 * step;
            default: hys_lsb = 4 * step;
        endcase
    endfunction

endpackage

// File: rtl/tlim_thresh.sv
module tlim_thresh #(
    parameter int TW       = 12,
    parameter int HYS_STEP = 16
) (
    input  logic signed [TW-1:0] lim_high,
    input  logic signed [TW-1:0] lim_low,
    input  logic        [1:0]    hys_code,
    output logic signed [TW-1:0] rel_high,
    output logic signed [TW-1:0] rel_low
);
    localparam int EW = TW + 2;
    localparam logic signed [EW-1:0] MAX_E = {3'b000, {(TW-1){1'b1}}};
    localparam logic signed [EW-1:0] MIN_E = {3'b111, {(TW-1){1'b0}}};

    logic signed [EW-1:0] hys_e;
    logic signed [EW-1:0] hi_e;
    logic signed [EW-1:0] lo_e;
    logic signed [EW-1:0] hi_sub;
    logic signed [EW-1:0] lo_add;

    always_comb begin
        hys_e  = EW'(tlim_pkg::hys_lsb(hys_code, HYS_STEP));
        hi_e   = {{2{lim_high[TW-1]}}, lim_high};
        lo_e   = {{2{lim_low[TW-1]}}, lim_low};
        hi_sub = hi_e - hys_e;
        lo_add = lo_e + hys_e;
        if (hi_sub < MIN_E) rel_high = MIN_E[TW-1:0];
        else                rel_high = hi_sub[TW-1:0];
        if (lo_add > MAX_E) rel_low = MAX_E[TW-1:0];
        else                rel_low = lo_add[TW-1:0];
    end

endmodule

// File: rtl/tlim_flags.sv
module tlim_flags #(
    parameter int TW = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  soft_rst,
    input  logic                  res_valid,
    input  logic signed [TW-1:0]  temp,
    input  logic signed [TW-1:0]  lim_high,
    input  logic signed [TW-1:0]  lim_low,
    input  logic signed [TW-1:0]  rel_high,
    input  logic signed [TW-1:0]  rel_low,
    input  logic                  mode_intr,
    input  logic                  cfg_rd_clr,
    input  logic                  ares_ok,
    output tlim_pkg::tlim_state_t st_q
);
    tlim_pkg::tlim_state_t st_d;
    logic over_w;
    logic under_w;

    always_comb begin
        over_w  = temp > lim_high;
        under_w = temp < lim_low;
        st_d    = st_q;
        if (mode_intr) begin
            if (cfg_rd_clr) begin
                st_d.fh   = 1'b0;
                st_d.fl   = 1'b0;
                st_d.alrt = 1'b0;
            end
            if (ares_ok) st_d.alrt = 1'b0;
            if (res_valid) begin
                if (over_w) begin
                    st_d.fh   = 1'b1;
                    st_d.alrt = 1'b1;
                end
                if (under_w) begin
                    st_d.fl   = 1'b1;
                    st_d.alrt = 1'b1;
                end
            end
        end else begin
            if (res_valid) begin
                if (over_w)                st_d.fh = 1'b1;
                else if (temp <= rel_high) st_d.fh = 1'b0;
                if (under_w)               st_d.fl = 1'b1;
                else if (temp >= rel_low)  st_d.fl = 1'b0;
            end
            st_d.alrt = st_d.fh | st_d.fl;
        end
        if (res_valid) begin
            if (over_w)       st_d.cause = 1'b1;
            else if (under_w) st_d.cause = 1'b0;
        end
        if (soft_rst) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (st_q == '0)); // R11
    AST_CFGRD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_intr && cfg_rd_clr && !res_valid && !soft_rst) |=> (!st_q.fh && !st_q.fl && !st_q.alrt)); // R7
    AST_ARES_PIN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_intr && ares_ok && !cfg_rd_clr && !res_valid && !soft_rst) |=> (!st_q.alrt && $stable({st_q.fh, st_q.fl}))); // R8
    AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!res_valid && !cfg_rd_clr && !soft_rst) |=> $stable({st_q.fh, st_q.fl})); // R13
    AST_OVER_SETS_FH: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !soft_rst && (temp > lim_high)) |=> (st_q.fh && st_q.cause)); // R2
    AST_CMP_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_intr && !$past(mode_intr)) |-> (st_q.alrt == (st_q.fh | st_q.fl))); // R4

endmodule

// File: rtl/tlim_pin.sv
module tlim_pin (
    input  logic alrt,
    input  logic pol_high,
    output logic pin
);
    always_comb begin
        if (pol_high) pin = alrt;
        else          pin = ~alrt;
    end
endmodule

// File: rtl/tlim_alert.sv
module tlim_alert #(
    parameter int TEMP_W   = 12,
    parameter int HYS_STEP = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              res_valid,
    input  logic [TEMP_W-1:0] res_temp,
    input  logic [TEMP_W-1:0] lim_high,
    input  logic [TEMP_W-1:0] lim_low,
    input  logic              mode_intr,
    input  logic              pol_high,
    input  logic [1:0]        hys_code,
    input  logic              cfg_rd_clr,
    input  logic              ares_ok,
    output logic              flag_hi,
    output logic              flag_lo,
    output logic              alert_o,
    output logic              alert_cause
);
    logic signed [TEMP_W-1:0] rel_high;
    logic signed [TEMP_W-1:0] rel_low;
    tlim_pkg::tlim_state_t    st_q;

    tlim_thresh #(.TW(TEMP_W), .HYS_STEP(HYS_STEP)) u_thresh (
        .lim_high (lim_high),
        .lim_low  (lim_low),
        .hys_code (hys_code),
        .rel_high (rel_high),
        .rel_low  (rel_low)
    );

    tlim_flags #(.TW(TEMP_W)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .res_valid  (res_valid),
        .temp       (res_temp),
        .lim_high   (lim_high),
        .lim_low    (lim_low),
        .rel_high   (rel_high),
        .rel_low    (rel_low),
        .mode_intr  (mode_intr),
        .cfg_rd_clr (cfg_rd_clr),
        .ares_ok    (ares_ok),
        .st_q       (st_q)
    );

    tlim_pin u_pin (
        .alrt     (st_q.alrt),
        .pol_high (pol_high),
        .pin      (alert_o)
    );

    assign flag_hi     = st_q.fh;
    assign flag_lo     = st_q.fl;
    assign alert_cause = st_q.cause;

endmodule

// File: tb/tlim_alert_tb.sv
module tlim_alert_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        res_valid = 1'b0;
    logic [11:0] res_temp = '0;
    logic [11:0] lim_high = 12'h7FF;
    logic [11:0] lim_low = 12'h800;
    logic        mode_intr = 1'b1;
    logic        pol_high = 1'b0;
    logic [1:0]  hys_code = 2'd1;
    logic        cfg_rd_clr = 1'b0;
    logic        ares_ok = 1'b0;
    logic        flag_hi, flag_lo, alert_o, alert_cause;

    logic [3:0]  exp_q[$];
    string       tag_q[$];
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    tlim_alert u_dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .res_valid(res_valid),
        .res_temp(res_temp), .lim_high(lim_high), .lim_low(lim_low),
        .mode_intr(mode_intr), .pol_high(pol_high), .hys_code(hys_code),
        .cfg_rd_clr(cfg_rd_clr), .ares_ok(ares_ok), .flag_hi(flag_hi),
        .flag_lo(flag_lo), .alert_o(alert_o), .alert_cause(alert_cause)
    );

    // expected order: {flag_hi, flag_lo, alert_o, alert_cause}
    task automatic step(input logic v, input logic [11:0] t, input logic crd,
                        input logic ar, input logic sr, input logic [3:0] exp,
                        input string tag);
        res_valid = v; res_temp = t; cfg_rd_clr = crd; ares_ok = ar; soft_rst = sr;
        @(posedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        res_valid = 1'b0; cfg_rd_clr = 1'b0; ares_ok = 1'b0; soft_rst = 1'b0;
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic [3:0] e;
                logic [3:0] a;
                string      tg;
                e  = exp_q.pop_front();
                tg = tag_q.pop_front();
                a  = {flag_hi, flag_lo, alert_o, alert_cause};
                n_chk++;
                if (a !== e) begin
                    n_fail++;
                    $display("FAIL %s: got fh/fl/pin/cause=%b expected %b", tg, a, e);
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 5000; i++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(0, 12'h000, 0, 0, 0, 4'b0010, "R1 reset state");
        // latched mode
        lim_high = 12'h190; lim_low = 12'h000;
        step(1, 12'h0A0, 0, 0, 0, 4'b0010, "R2 in window");
        step(1, 12'h190, 0, 0, 0, 4'b0010, "R2 equal to high");
        step(1, 12'h191, 0, 0, 0, 4'b1001, "R2 R10 over sets");
        step(1, 12'h0A0, 0, 0, 0, 4'b1001, "R2 sticky");
        step(0, 12'h000, 0, 1, 0, 4'b1011, "R8 response clears pin only");
        step(0, 12'h000, 1, 0, 0, 4'b0011, "R7 read clears flags");
        step(1, 12'hE70, 0, 0, 0, 4'b0100, "R3 R10 negative under");
        lim_high = 12'h7FF; lim_low = 12'hE00;
        step(0, 12'h000, 0, 0, 0, 4'b0100, "R13 limits change only");
        step(1, 12'hC90, 1, 0, 0, 4'b0100, "R12 event beats clear");
        step(0, 12'h000, 1, 0, 0, 4'b0010, "R7 read clears");
        pol_high = 1'b1;
        step(0, 12'h000, 0, 0, 0, 4'b0000, "R9 inactive high pol");
        lim_high = 12'h320;
        step(1, 12'h400, 0, 0, 0, 4'b1011, "R9 active high pol");
        pol_high = 1'b0;
        step(0, 12'h000, 0, 0, 1, 4'b0010, "R11 soft reset");
        // window-follow mode
        mode_intr = 1'b0; lim_high = 12'h320; lim_low = 12'h100; hys_code = 2'd1;
        step(1, 12'h321, 0, 0, 0, 4'b1001, "R4 over");
        step(1, 12'h311, 0, 0, 0, 4'b1001, "R4 R5 hold in margin");
        step(0, 12'h000, 1, 0, 0, 4'b1001, "R7 read ignored");
        step(0, 12'h000, 0, 1, 0, 4'b1001, "R8 response ignored");
        step(1, 12'h310, 0, 0, 0, 4'b0011, "R4 release");
        hys_code = 2'd3;
        step(1, 12'h0FF, 0, 0, 0, 4'b0100, "R4 under");
        step(1, 12'h13F, 0, 0, 0, 4'b0100, "R5 hold margin 64");
        step(1, 12'h140, 0, 0, 0, 4'b0010, "R5 release margin 64");
        hys_code = 2'd2;
        step(1, 12'h321, 0, 0, 0, 4'b1001, "R5 over");
        step(1, 12'h300, 0, 0, 0, 4'b0011, "R5 release margin 32");
        hys_code = 2'd0;
        step(1, 12'h321, 0, 0, 0, 4'b1001, "R5 over");
        step(1, 12'h320, 0, 0, 0, 4'b0011, "R5 release margin 0");
        // saturation
        hys_code = 2'd3; lim_high = 12'h7FF; lim_low = 12'h7F0;
        step(1, 12'h7E0, 0, 0, 0, 4'b0100, "R6 under near top");
        step(1, 12'h7F8, 0, 0, 0, 4'b0100, "R6 hold below saturated");
        step(1, 12'h7FF, 0, 0, 0, 4'b0010, "R6 release at 0x7FF");
        lim_high = 12'h810; lim_low = 12'h800;
        step(1, 12'h820, 0, 0, 0, 4'b1001, "R6 over near bottom");
        step(1, 12'h808, 0, 0, 0, 4'b1001, "R6 hold above saturated");
        step(1, 12'h800, 0, 0, 0, 4'b0011, "R6 release at 0x800");
        repeat (3) @(negedge clk);
        done = 1'b1;
        report();
    end

endmodule